// File: doc/BRIEF.md
# Random Generator Host Register Bank

This block is the host-facing register bank of a true random number generator. A generator core delivers a 128-bit result with a one-cycle valid strobe. The bank keeps that result in four 32-bit output words and raises a ready flag. It can also raise an interrupt. The host reads the words and then clears the flag by writing a one to the acknowledge location. The acknowledge location has the same address as the read-only status word.

The bank also holds the settings that the core uses:

- the global run enable;
- the noise-block and sample-cycle counts;
- the per-oscillator enable and detune masks;
- the alarm threshold, alarm mask and alarm stop masks;
- a constant revision word.

The two count fields are frozen while the generator runs, so software cannot change them under a running core. The bus is a plain single-cycle read/write port. Read data is combinational from the address.

Top module: `trng_regbank`

## Requirements
- R1: After reset the ready flag, the enable bit, the interrupt mask, every output word, the configuration counts, the oscillator, detune and alarm registers all read zero and irq is low.
- R2: When core_valid is high while ready is clear, the bank latches core_result, with word k (byte offset 4k, k = 0..3) taking bits [32k+31:32k]. Ready is set on the next cycle and appears as bit 0 of the status word at offset 0x10.
- R3: While ready is set, core_valid is ignored and the output words keep their contents.
- R4: Reading the output words does not change ready. Writes to offsets 0x00 to 0x0C are ignored.
- R5: A write to offset 0x10 with bit 0 set clears ready. A write there with bit 0 clear has no effect. When such a clearing write and core_valid arrive in the same cycle with ready set, ready is cleared and the new result is dropped.
- R6: The control word at offset 0x14 keeps only bit 10, the generator enable, which drives gen_enable. All its other bits read zero.
- R7: The configuration word at offset 0x18 holds the noise-block count in bits [7:0] and the sample-cycle count in bits [23:16]. Its other bits read zero. A write to it is ignored while the enable bit is 1.
- R8: The oscillator-enable word (0x20) and the detune word (0x24) each keep their low FRO_N bits (24 by default). Higher bits read zero.
- R9: The alarm threshold at 0x1C keeps 8 bits [7:0]. The alarm mask at 0x28 and the alarm stop at 0x2C each keep FRO_N low bits. All three drive their output ports.
- R10: The read-only word at 0x7C returns 0x4C in bits [7:0], REV_MAJOR in [27:24], REV_MINOR in [23:20], REV_PATCH in [19:16], and zero elsewhere. Writes to it are ignored.
- R11: The interrupt mask at 0x30 keeps bit 0, and irq equals ready AND that bit.
- R12: A read of any unmapped word address returns zero. bus_rdata is zero whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read enable |
| bus_addr | input | ADDR_W (7) | Byte address, low two bits ignored |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational |
| core_valid | input | 1 | Result strobe from the generator core |
| core_result | input | WORDS*DATA_W (128) | Result from the generator core |
| irq | output | 1 | Ready interrupt |
| gen_enable | output | 1 | Generator run enable |
| noise_blocks | output | 8 | Noise-block count |
| sample_cycles | output | 8 | Sample-cycle count |
| osc_enable | output | FRO_N (24) | Per-oscillator enable mask |
| osc_detune | output | FRO_N (24) | Per-oscillator detune mask |
| alarm_threshold | output | 8 | Alarm count threshold |
| alarm_mask | output | FRO_N (24) | Alarm mask |
| alarm_stop | output | FRO_N (24) | Alarm stop mask |

## Verification
The bench drives a second result while the first is still pending. A bank that overwrote the held result would return the wrong words on the next read. It also places a clearing write in the same cycle as a new strobe. A design that gave the strobe priority would leave ready set or latch the new data.

The bench writes configuration while enabled, then writes it again after disabling. A missing lock would change the counts, and an over-eager lock would refuse the second write. Zero writes to the acknowledge location, writes to the output words and reads of unmapped or disabled-read addresses each expose a decoder that lets stray traffic reach state or data.

// File: rtl/trng_regbank_pkg.sv
package trng_regbank_pkg;

   // word indices (byte offset / 4); the host software depends on them
   localparam int unsigned IDX_OUT0  = 0;
   localparam int unsigned IDX_STAT  = 4;
   localparam int unsigned IDX_CTRL  = 5;
   localparam int unsigned IDX_CFG   = 6;
   localparam int unsigned IDX_ACNT  = 7;
   localparam int unsigned IDX_FROEN = 8;
   localparam int unsigned IDX_DET   = 9;
   localparam int unsigned IDX_AMASK = 10;
   localparam int unsigned IDX_ASTOP = 11;
   localparam int unsigned IDX_IMASK = 12;
   localparam int unsigned IDX_REV   = 31;

   localparam int unsigned EN_BIT    = 10;
   localparam logic [7:0]  REV_ID    = 8'h4C;

   typedef enum logic [3:0] {
      RID_OUT,
      RID_STAT,
      RID_CTRL,
      RID_CFG,
      RID_ACNT,
      RID_FROEN,
      RID_DET,
      RID_AMASK,
      RID_ASTOP,
      RID_IMASK,
      RID_REV,
      RID_NONE
   } reg_id_e;

endpackage

// File: rtl/trng_addr_decode.sv
module trng_addr_decode
   import trng_regbank_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned WORDS  = 4
) (
   input  logic [ADDR_W-1:0]    addr,
   output reg_id_e              rid,
   output logic [ADDR_W-3:0]    widx
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   generate
      if (ADDR_W < 7) begin : g_addr_chk
         $error("ADDR_W must reach offset 0x7C");
      end
   endgenerate

   assign widx = addr[ADDR_W-1:2];

   always_comb begin
      rid = RID_NONE;
      if (int'(widx) < WORDS)                 rid = RID_OUT;
      else if (widx == IDX_W'(IDX_STAT))      rid = RID_STAT;
      else if (widx == IDX_W'(IDX_CTRL))      rid = RID_CTRL;
      else if (widx == IDX_W'(IDX_CFG))       rid = RID_CFG;
      else if (widx == IDX_W'(IDX_ACNT))      rid = RID_ACNT;
      else if (widx == IDX_W'(IDX_FROEN))     rid = RID_FROEN;
      else if (widx == IDX_W'(IDX_DET))       rid = RID_DET;
      else if (widx == IDX_W'(IDX_AMASK))     rid = RID_AMASK;
      else if (widx == IDX_W'(IDX_ASTOP))     rid = RID_ASTOP;
      else if (widx == IDX_W'(IDX_IMASK))     rid = RID_IMASK;
      else if (widx == IDX_W'(IDX_REV))       rid = RID_REV;
   end

endmodule

// File: rtl/trng_result_hold.sv
module trng_result_hold #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORDS  = 4,
   localparam int unsigned RES_W = DATA_W * WORDS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             core_valid,
   input  logic [RES_W-1:0] core_result,
   input  logic             ack,
   output logic             ready,
   output logic [RES_W-1:0] words
);
   logic capture;

   assign capture = core_valid && !ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready <= 1'b0;
      end else if (ready) begin
         if (ack) ready <= 1'b0;
      end else if (core_valid) begin
         ready <= 1'b1;
      end
   end

   generate
      for (genvar k = 0; k < WORDS; k++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               words[k*DATA_W +: DATA_W] <= '0;
            else if (capture)
               words[k*DATA_W +: DATA_W] <= core_result[k*DATA_W +: DATA_W];
         end
      end
   endgenerate

   // R2
   rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(core_valid));

   // R5
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && ack) |=> !ready);

   // R3
   hold_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> $stable(words));

endmodule

// File: rtl/trng_cfg_bank.sv
module trng_cfg_bank
   import trng_regbank_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FRO_N  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  reg_id_e           rid,
   input  logic [DATA_W-1:0] wdata,
   output logic              enable,
   output logic [7:0]        noise_blocks,
   output logic [7:0]        sample_cycles,
   output logic [FRO_N-1:0]  osc_enable,
   output logic [FRO_N-1:0]  osc_detune,
   output logic [7:0]        alarm_threshold,
   output logic [FRO_N-1:0]  alarm_mask,
   output logic [FRO_N-1:0]  alarm_stop,
   output logic              irq_mask
);
   logic cfg_open;

   assign cfg_open = !enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable          <= 1'b0;
         noise_blocks    <= '0;
         sample_cycles   <= '0;
         osc_enable      <= '0;
         osc_detune      <= '0;
         alarm_threshold <= '0;
         alarm_mask      <= '0;
         alarm_stop      <= '0;
         irq_mask        <= 1'b0;
      end else if (wr) begin
         unique case (rid)
            RID_CTRL:  enable <= wdata[EN_BIT];
            RID_CFG: begin
               if (cfg_open) begin
                  noise_blocks  <= wdata[7:0];
                  sample_cycles <= wdata[23:16];
               end
            end
            RID_ACNT:  alarm_threshold <= wdata[7:0];
            RID_FROEN: osc_enable      <= wdata[FRO_N-1:0];
            RID_DET:   osc_detune      <= wdata[FRO_N-1:0];
            RID_AMASK: alarm_mask      <= wdata[FRO_N-1:0];
            RID_ASTOP: alarm_stop      <= wdata[FRO_N-1:0];
            RID_IMASK: irq_mask        <= wdata[0];
            default: ;
         endcase
      end
   end

   // R7
   cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> $stable({noise_blocks, sample_cycles}));

endmodule

// File: rtl/trng_regbank.sv
module trng_regbank
   import trng_regbank_pkg::*;
#(
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned WORDS     = 4,
   parameter int unsigned FRO_N     = 24,
   parameter bit          IRQ_EN    = 1'b1,
   parameter logic [3:0]  REV_MAJOR = 4'd2,
   parameter logic [3:0]  REV_MINOR = 4'd3,
   parameter logic [3:0]  REV_PATCH = 4'd1,
   localparam int unsigned RES_W    = DATA_W * WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              core_valid,
   input  logic [RES_W-1:0]  core_result,
   output logic              irq,
   output logic              gen_enable,
   output logic [7:0]        noise_blocks,
   output logic [7:0]        sample_cycles,
   output logic [FRO_N-1:0]  osc_enable,
   output logic [FRO_N-1:0]  osc_detune,
   output logic [7:0]        alarm_threshold,
   output logic [FRO_N-1:0]  alarm_mask,
   output logic [FRO_N-1:0]  alarm_stop
);
   generate
      if (DATA_W != 32) begin : g_dw_chk
         $error("DATA_W must be 32");
      end
      if (FRO_N < 1 || FRO_N > DATA_W) begin : g_fro_chk
         $error("FRO_N out of range");
      end
      if (WORDS < 1 || WORDS > 4) begin : g_words_chk
         $error("WORDS must be 1..4");
      end
   endgenerate

   reg_id_e           rid;
   logic [ADDR_W-3:0] widx;
   logic              ready;
   logic [RES_W-1:0]  words;
   logic              ack;
   logic              irq_mask;
   logic [DATA_W-1:0] rev_word;
   logic [DATA_W-1:0] rd_mux;

   trng_addr_decode #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_dec (
      .addr (bus_addr),
      .rid  (rid),
      .widx (widx)
   );

   assign ack = bus_wr && (rid == RID_STAT) && bus_wdata[0];

   trng_result_hold #(.DATA_W(DATA_W), .WORDS(WORDS)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .core_valid  (core_valid),
      .core_result (core_result),
      .ack         (ack),
      .ready       (ready),
      .words       (words)
   );

   trng_cfg_bank #(.DATA_W(DATA_W), .FRO_N(FRO_N)) u_cfg (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr              (bus_wr),
      .rid             (rid),
      .wdata           (bus_wdata),
      .enable          (gen_enable),
      .noise_blocks    (noise_blocks),
      .sample_cycles   (sample_cycles),
      .osc_enable      (osc_enable),
      .osc_detune      (osc_detune),
      .alarm_threshold (alarm_threshold),
      .alarm_mask      (alarm_mask),
      .alarm_stop      (alarm_stop),
      .irq_mask        (irq_mask)
   );

   assign rev_word = {4'h0, REV_MAJOR, REV_MINOR, REV_PATCH, 8'h00, REV_ID};

   always_comb begin
      rd_mux = '0;
      unique case (rid)
         RID_OUT:   rd_mux = words[widx[1:0]*DATA_W +: DATA_W];
         RID_STAT:  rd_mux = DATA_W'(ready);
         RID_CTRL:  rd_mux = DATA_W'(gen_enable) << EN_BIT;
         RID_CFG:   rd_mux = {8'h00, sample_cycles, 8'h00, noise_blocks};
         RID_ACNT:  rd_mux = DATA_W'(alarm_threshold);
         RID_FROEN: rd_mux = DATA_W'(osc_enable);
         RID_DET:   rd_mux = DATA_W'(osc_detune);
         RID_AMASK: rd_mux = DATA_W'(alarm_mask);
         RID_ASTOP: rd_mux = DATA_W'(alarm_stop);
         RID_IMASK: rd_mux = DATA_W'(irq_mask);
         RID_REV:   rd_mux = rev_word;
         default:   rd_mux = '0;
      endcase
   end

   assign bus_rdata = bus_rd ? rd_mux : '0;

   generate
      if (IRQ_EN) begin : g_irq
         assign irq = ready && irq_mask;
      end else begin : g_noirq
         assign irq = 1'b0;
      end
   endgenerate

endmodule

// File: tb/trng_regbank_tb.sv
module trng_regbank_tb;
   localparam logic [3:0] MAJ = 4'd2, MIN = 4'd3, PAT = 4'd1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0, bus_rd = 1'b0, core_valid = 1'b0;
   logic [6:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0, bus_rdata;
   logic [127:0] core_result = '0;
   logic         irq, gen_enable;
   logic [7:0]   noise_blocks, sample_cycles, alarm_threshold;
   logic [23:0]  osc_enable, osc_detune, alarm_mask, alarm_stop;

   int tests = 0, fails = 0;

   // behavioural model state
   logic [31:0] m_w [4];
   bit          m_rdy, m_en, m_imask;
   logic [7:0]  m_noise, m_samp, m_acnt;
   logic [23:0] m_fro, m_det, m_amask, m_astop;

   always #5 clk = ~clk;

   trng_regbank #(.REV_MAJOR(MAJ), .REV_MINOR(MIN), .REV_PATCH(PAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .core_valid(core_valid), .core_result(core_result), .irq(irq),
      .gen_enable(gen_enable), .noise_blocks(noise_blocks),
      .sample_cycles(sample_cycles), .osc_enable(osc_enable),
      .osc_detune(osc_detune), .alarm_threshold(alarm_threshold),
      .alarm_mask(alarm_mask), .alarm_stop(alarm_stop)
   );

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [6:0] a);
      int idx = int'(a[6:2]);
      case (idx)
         0, 1, 2, 3: return m_w[idx];
         4:  return {31'b0, m_rdy};
         5:  return {21'b0, m_en, 10'b0};
         6:  return {8'h0, m_samp, 8'h0, m_noise};
         7:  return {24'h0, m_acnt};
         8:  return {8'h0, m_fro};
         9:  return {8'h0, m_det};
         10: return {8'h0, m_amask};
         11: return {8'h0, m_astop};
         12: return {31'b0, m_imask};
         31: return {4'h0, MAJ, MIN, PAT, 8'h00, 8'h4C};
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_update(input bit wr, input logic [6:0] a, input logic [31:0] d,
                               input bit v, input logic [127:0] res);
      int  idx = int'(a[6:2]);
      bit  was_en = m_en;
      if (m_rdy) begin
         if (wr && idx == 4 && d[0]) m_rdy = 1'b0;
      end else if (v) begin
         m_rdy = 1'b1;
         for (int k = 0; k < 4; k++) m_w[k] = res[k*32 +: 32];
      end
      if (wr) begin
         case (idx)
            5:  m_en = d[10];
            6:  if (!was_en) begin m_noise = d[7:0]; m_samp = d[23:16]; end
            7:  m_acnt = d[7:0];
            8:  m_fro = d[23:0];
            9:  m_det = d[23:0];
            10: m_amask = d[23:0];
            11: m_astop = d[23:0];
            12: m_imask = d[0];
            default: ;
         endcase
      end
   endtask

   task automatic check_outputs(input string tag);
      check({tag, " irq"}, irq, m_rdy & m_imask);
      check({tag, " en"}, gen_enable, m_en);
      check({tag, " cfg"}, {noise_blocks, sample_cycles}, {m_noise, m_samp});
      check({tag, " osc"}, {osc_enable, osc_detune}, {m_fro, m_det});
      check({tag, " alarm"}, {alarm_threshold, alarm_mask, alarm_stop}, {m_acnt, m_amask, m_astop});
   endtask

   // one bus/core cycle; called at a falling edge
   task automatic step(input bit wr, input bit rd, input logic [6:0] a, input logic [31:0] d,
                       input bit v, input logic [127:0] res, input string tag);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      core_valid = v; core_result = res;
      #1;
      if (rd) check({tag, " rdata"}, bus_rdata, model_read(a));
      else    check({tag, " idle rdata"}, bus_rdata, 32'h0);
      @(posedge clk);
      model_update(wr, a, d, v, res);
      @(negedge clk);
      check_outputs(tag);
   endtask

   task automatic wr32(input logic [6:0] a, input logic [31:0] d, input string tag);
      step(1'b1, 1'b0, a, d, 1'b0, '0, tag);
   endtask
   task automatic rd32(input logic [6:0] a, input string tag);
      step(1'b0, 1'b1, a, 32'h0, 1'b0, '0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog expired actual running expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [127:0] r1 = 128'h0123456789ABCDEF_FEDCBA9876543210;
      logic [127:0] r2 = 128'hDEADBEEFCAFEF00D_1122334455667788;
      logic [127:0] r3 = 128'hA5A5A5A55A5A5A5A_0F0F0F0FF0F0F0F0;
      m_rdy = 0; m_en = 0; m_imask = 0; m_noise = 0; m_samp = 0; m_acnt = 0;
      m_fro = 0; m_det = 0; m_amask = 0; m_astop = 0;
      for (int k = 0; k < 4; k++) m_w[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state over every mapped word
      check_outputs("R1 reset");
      for (int i = 0; i < 13; i++) rd32(7'(i * 4), "R1 reset read");
      // R10 revision word, write ignored
      rd32(7'h7C, "R10 rev");
      wr32(7'h7C, 32'hFFFFFFFF, "R10 rev write");
      rd32(7'h7C, "R10 rev after write");
      // R12 unmapped and rd low
      rd32(7'h40, "R12 unmapped");
      rd32(7'h78, "R12 unmapped hi");
      step(1'b0, 1'b0, 7'h7C, 32'h0, 1'b0, '0, "R12 rd low");
      // R7 config open while disabled
      wr32(7'h18, 32'hABCD1234, "R7 cfg write");
      rd32(7'h18, "R7 cfg read");
      // R6 enable
      wr32(7'h14, 32'hFFFFFFFF, "R6 ctrl write");
      rd32(7'h14, "R6 ctrl read");
      // R7 locked
      wr32(7'h18, 32'h00770088, "R7 cfg locked");
      rd32(7'h18, "R7 cfg still");
      wr32(7'h14, 32'h0, "R6 disable");
      wr32(7'h18, 32'h00220005, "R7 cfg reopen");
      rd32(7'h18, "R7 cfg new");
      // R8 oscillators
      wr32(7'h20, 32'hFFFFFFFF, "R8 fro");
      rd32(7'h20, "R8 fro read");
      wr32(7'h24, 32'h12345678, "R8 det");
      rd32(7'h24, "R8 det read");
      // R9 alarm
      wr32(7'h1C, 32'h1234569A, "R9 acnt");
      wr32(7'h28, 32'hF0F0F0F0, "R9 amask");
      wr32(7'h2C, 32'h0F0F0F0F, "R9 astop");
      rd32(7'h1C, "R9 acnt read");
      rd32(7'h28, "R9 amask read");
      rd32(7'h2C, "R9 astop read");
      // R11 mask on
      wr32(7'h30, 32'hFFFFFFFF, "R11 imask");
      rd32(7'h30, "R11 imask read");
      // R2 capture
      step(1'b0, 1'b0, 7'h0, 32'h0, 1'b1, r1, "R2 capture");
      rd32(7'h10, "R2 status");
      for (int k = 0; k < 4; k++) rd32(7'(k * 4), "R2 word");
      // R4 reads keep ready, writes to words ignored
      rd32(7'h10, "R4 ready kept");
      wr32(7'h04, 32'h55555555, "R4 word write");
      rd32(7'h04, "R4 word unchanged");
      // R3 second result ignored
      step(1'b0, 1'b0, 7'h0, 32'h0, 1'b1, r2, "R3 valid while ready");
      for (int k = 0; k < 4; k++) rd32(7'(k * 4), "R3 word hold");
      // R5 zero write no effect, one clears
      wr32(7'h10, 32'hFFFFFFFE, "R5 ack zero");
      rd32(7'h10, "R5 still ready");
      wr32(7'h10, 32'h1, "R5 ack");
      rd32(7'h10, "R5 cleared");
      // R2 new capture then R5 ack with simultaneous valid
      step(1'b0, 1'b0, 7'h0, 32'h0, 1'b1, r2, "R2 capture 2");
      for (int k = 0; k < 4; k++) rd32(7'(k * 4), "R2 word 2");
      step(1'b1, 1'b0, 7'h10, 32'h1, 1'b1, r3, "R5 ack vs valid");
      rd32(7'h10, "R5 dropped");
      rd32(7'h0C, "R5 old word");
      // R11 mask off with ready
      step(1'b0, 1'b0, 7'h0, 32'h0, 1'b1, r3, "R2 capture 3");
      wr32(7'h30, 32'h0, "R11 imask off");
      wr32(7'h30, 32'h1, "R11 imask on");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule